// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller for a five-stage in-order pipeline whose branches resolve in the decode/register-read stage. Every cycle it compares the source registers of the instruction in decode with the destinations of the instructions in execute and memory. From that comparison it picks an operand source for each decode operand: the register file, the execute-stage result, or the memory-stage result. Forwarding into decode, not into execute, lets the branch comparator work on current values.

A load in execute cannot supply its data in time. When the instruction in decode depends on such a load, the block holds the PC and the IF/ID register for one cycle and sends a bubble into ID/EX. On the next cycle the load data reaches decode through the memory-stage path. Branches are predicted not taken. A taken BEQ, a taken BNE or any JAL raises a redirect and a squash that sets the IF/ID nop bit, so the one instruction fetched down the wrong path is discarded.

Top module: `hazard_ctrl`

## Requirements
- R1: When a live execute-stage producer (write enable high, nop low) writes a register that decode reads, that operand's select is 1 (execute result).
- R2: When only a live memory-stage producer matches a read source, the select is 2 (memory result). With no match the select is 0 (register file).
- R3: When both the execute and memory producers match the same source, the execute result wins (select 1).
- R4: A destination or source of register 0 never causes forwarding or a stall.
- R5: A producer whose nop bit is set, or whose write enable is low, is never matched.
- R6: A source whose use flag is low is ignored by forwarding and by the stall check.
- R7: A JAL in decode always raises flush and redirect. Both of its sources are ignored, whatever their use flags.
- R8: A read source that matches a live load in execute raises stall and bubble for that cycle. A matching non-load producer raises no stall. In the following cycle, with the load in memory, the operand select is 2.
- R9: A load in execute that matches only an unused source causes no stall.
- R10: A branch in decode is taken when the equality input is 1 for BEQ (branch-ne input 0), or when it is 0 for BNE (branch-ne input 1). A taken branch raises flush and redirect.
- R11: When stall and a taken branch fall in the same cycle, stall wins: flush and redirect stay low.
- R12: When decode holds a nop (decode-valid low), stall, bubble, flush and redirect are low and both selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used for checks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_valid_i | input | 1 | Decode holds a real instruction (nop bit clear) |
| id_rs1_i | input | AW | Decode source 1 register |
| id_rs2_i | input | AW | Decode source 2 register |
| id_use_rs1_i | input | 1 | Decode reads source 1 |
| id_use_rs2_i | input | 1 | Decode reads source 2 |
| id_is_branch_i | input | 1 | Decode holds a conditional branch |
| id_branch_ne_i | input | 1 | Branch is taken on not-equal |
| id_is_jal_i | input | 1 | Decode holds a JAL |
| id_operands_eq_i | input | 1 | Forwarded decode operands are equal |
| ex_rd_i | input | AW | Execute-stage destination |
| ex_we_i | input | 1 | Execute-stage writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| ex_nop_i | input | 1 | Execute-stage nop bit |
| mem_rd_i | input | AW | Memory-stage destination |
| mem_we_i | input | 1 | Memory-stage writes a register |
| mem_nop_i | input | 1 | Memory-stage nop bit |
| fwd_a_o | output | 2 | Operand 1 source: 0 regfile, 1 execute, 2 memory |
| fwd_b_o | output | 2 | Operand 2 source: 0 regfile, 1 execute, 2 memory |
| stall_o | output | 1 | Hold PC and IF/ID |
| bubble_o | output | 1 | Insert nop into ID/EX |
| flush_o | output | 1 | Set the IF/ID nop bit |
| redirect_o | output | 1 | Fetch from the branch or jump target next |

## Verification
The two functions that can land in one cycle are the load-use stall and a taken branch redirect. A branch that is about to be taken can read a register that a load in execute is still producing. The bench provokes this with a BEQ whose equality input is 1 while its source matches a live load in execute. It judges the result by requiring stall and bubble high and flush and redirect low. A second coincidence is a double match on one source. The bench sets the execute and memory destinations to the same register and requires the execute select.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_EX  = 2'd1,
    FWD_MEM = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_fwd.sv
module hz_src_fwd
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          id_valid_i,
  input  logic [AW-1:0] rs_i,
  input  logic          use_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_live_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_live_i,
  output fwd_sel_e      sel_o
);
  logic rs_nz, ex_hit, mem_hit;

  assign rs_nz   = |rs_i;
  assign ex_hit  = ex_live_i  && (ex_rd_i  == rs_i);
  assign mem_hit = mem_live_i && (mem_rd_i == rs_i);

  always_comb begin
    sel_o = FWD_RF;
    if (id_valid_i && use_i && rs_nz) begin
      if (ex_hit)       sel_o = FWD_EX;   // younger result first
      else if (mem_hit) sel_o = FWD_MEM;
    end
  end

  assert_no_x0_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != FWD_RF) |-> (rs_i != '0));
  assert_unused_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_i |-> (sel_o == FWD_RF));
  assert_mem_needs_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == FWD_MEM) |-> (mem_live_i && mem_rd_i == rs_i));
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          id_valid_i,
  input  logic [AW-1:0] rs_a_i,
  input  logic          use_a_i,
  input  logic [AW-1:0] rs_b_i,
  input  logic          use_b_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_live_i,
  input  logic          ex_load_i,
  output logic          stall_o
);
  logic ld_live, hit_a, hit_b;

  assign ld_live = ex_live_i && ex_load_i && (ex_rd_i != '0);
  assign hit_a   = use_a_i && (rs_a_i == ex_rd_i);
  assign hit_b   = use_b_i && (rs_b_i == ex_rd_i);
  assign stall_o = id_valid_i && ld_live && (hit_a || hit_b);

  assert_stall_from_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_load_i && ex_live_i));
  assert_stall_not_x0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_rd_i != '0));
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic id_valid_i,
  input  logic stall_i,
  input  logic is_branch_i,
  input  logic branch_ne_i,
  input  logic operands_eq_i,
  input  logic is_jal_i,
  output logic taken_o
);
  logic cond_met;

  assign cond_met = is_branch_i && (operands_eq_i ^ branch_ne_i);
  // operands are not final while stalled, so no resolution then
  assign taken_o  = id_valid_i && !stall_i && (is_jal_i || cond_met);

  assert_stall_over_redirect_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !taken_o);
  assert_jal_taken_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && is_jal_i && !stall_i) |-> taken_o);
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          id_valid_i,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic          id_use_rs1_i,
  input  logic          id_use_rs2_i,
  input  logic          id_is_branch_i,
  input  logic          id_branch_ne_i,
  input  logic          id_is_jal_i,
  input  logic          id_operands_eq_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic          ex_nop_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic          mem_nop_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          stall_o,
  output logic          bubble_o,
  output logic          flush_o,
  output logic          redirect_o
);
  localparam int NSRC = 2;

  logic [AW-1:0] src     [NSRC];
  logic          use_eff [NSRC];
  fwd_sel_e      sel     [NSRC];
  logic          ex_live, mem_live, stall, taken;

  assign ex_live  = ex_we_i  && !ex_nop_i;
  assign mem_live = mem_we_i && !mem_nop_i;

  assign src[0]     = id_rs1_i;
  assign src[1]     = id_rs2_i;
  assign use_eff[0] = id_use_rs1_i && !id_is_jal_i;  // JAL reads nothing
  assign use_eff[1] = id_use_rs2_i && !id_is_jal_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_src_fwd #(.AW(AW)) u_fwd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .id_valid_i (id_valid_i),
      .rs_i       (src[g]),
      .use_i      (use_eff[g]),
      .ex_rd_i    (ex_rd_i),
      .ex_live_i  (ex_live),
      .mem_rd_i   (mem_rd_i),
      .mem_live_i (mem_live),
      .sel_o      (sel[g])
    );
  end

  hz_load_use #(.AW(AW)) u_load_use (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .id_valid_i (id_valid_i),
    .rs_a_i     (src[0]),
    .use_a_i    (use_eff[0]),
    .rs_b_i     (src[1]),
    .use_b_i    (use_eff[1]),
    .ex_rd_i    (ex_rd_i),
    .ex_live_i  (ex_live),
    .ex_load_i  (ex_load_i),
    .stall_o    (stall)
  );

  hz_redirect u_redirect (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .id_valid_i    (id_valid_i),
    .stall_i       (stall),
    .is_branch_i   (id_is_branch_i),
    .branch_ne_i   (id_branch_ne_i),
    .operands_eq_i (id_operands_eq_i),
    .is_jal_i      (id_is_jal_i),
    .taken_o       (taken)
  );

  assign fwd_a_o    = sel[0];
  assign fwd_b_o    = sel[1];
  assign stall_o    = stall;
  assign bubble_o   = stall;
  assign flush_o    = taken;
  assign redirect_o = taken;

  assert_idle_id_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |-> (!stall_o && !flush_o && fwd_a_o == 2'd0 && fwd_b_o == 2'd0));
  assert_dead_ex_no_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_nop_i || !ex_we_i) |-> !stall_o);
endmodule

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          id_valid, use1, use2, is_br, br_ne, is_jal, op_eq;
  logic [AW-1:0] rs1, rs2, ex_rd, mem_rd;
  logic          ex_we, ex_ld, ex_nop, mem_we, mem_nop;
  logic [1:0]    fwd_a, fwd_b;
  logic          stall, bubble, flush, redirect;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hazard_ctrl #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .id_valid_i(id_valid), .id_rs1_i(rs1), .id_rs2_i(rs2),
    .id_use_rs1_i(use1), .id_use_rs2_i(use2),
    .id_is_branch_i(is_br), .id_branch_ne_i(br_ne), .id_is_jal_i(is_jal),
    .id_operands_eq_i(op_eq),
    .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_ld), .ex_nop_i(ex_nop),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_nop_i(mem_nop),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall), .bubble_o(bubble),
    .flush_o(flush), .redirect_o(redirect)
  );

  typedef struct packed {
    logic [3:0]    req;
    logic [AW-1:0] rs1, rs2;
    logic          u1, u2, idv, br, ne, jal, eq;
    logic [AW-1:0] exrd;
    logic          exwe, exld, exnop;
    logic [AW-1:0] memrd;
    logic          memwe, memnop;
    logic [1:0]    ea, eb;
    logic          es, ef;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    // R1 execute forward
    '{4'd1, 5'd3, 5'd4, 1,1,1,0,0,0,0, 5'd3,1,0,0, 5'd0,0,0, 2'd1,2'd0,0,0},
    // R2 memory forward
    '{4'd2, 5'd3, 5'd4, 1,1,1,0,0,0,0, 5'd7,1,0,0, 5'd4,1,0, 2'd0,2'd2,0,0},
    // R3 execute over memory
    '{4'd3, 5'd5, 5'd5, 1,1,1,0,0,0,0, 5'd5,1,0,0, 5'd5,1,0, 2'd1,2'd1,0,0},
    // R4 x0 never matches
    '{4'd4, 5'd0, 5'd0, 1,1,1,0,0,0,0, 5'd0,1,1,0, 5'd0,1,0, 2'd0,2'd0,0,0},
    // R5 nop execute, write-disabled memory
    '{4'd5, 5'd6, 5'd6, 1,1,1,0,0,0,0, 5'd6,1,1,1, 5'd6,0,0, 2'd0,2'd0,0,0},
    // R5 write-disabled execute, nop memory
    '{4'd5, 5'd6, 5'd8, 1,1,1,0,0,0,0, 5'd6,0,1,0, 5'd8,1,1, 2'd0,2'd0,0,0},
    // R6 unused rs2
    '{4'd6, 5'd2, 5'd9, 1,0,1,0,0,0,0, 5'd9,1,0,0, 5'd9,1,0, 2'd0,2'd0,0,0},
    // R7 JAL ignores sources, always taken
    '{4'd7, 5'd4, 5'd4, 1,1,1,0,0,1,0, 5'd4,1,1,0, 5'd4,1,0, 2'd0,2'd0,0,1},
    // R8 load-use stall
    '{4'd8, 5'd4, 5'd1, 1,0,1,0,0,0,0, 5'd4,1,1,0, 5'd0,0,0, 2'd1,2'd0,1,0},
    // R8 ALU producer: forward, no stall
    '{4'd8, 5'd4, 5'd2, 1,1,1,1,0,0,0, 5'd4,1,0,0, 5'd0,0,0, 2'd1,2'd0,0,0},
    // R9 load matches unused source
    '{4'd9, 5'd1, 5'd4, 1,0,1,0,0,0,0, 5'd4,1,1,0, 5'd0,0,0, 2'd0,2'd0,0,0},
    // R10 BEQ equal -> taken
    '{4'd10,5'd1, 5'd2, 1,1,1,1,0,0,1, 5'd0,0,0,0, 5'd0,0,0, 2'd0,2'd0,0,1},
    // R10 BEQ unequal -> not taken
    '{4'd10,5'd1, 5'd2, 1,1,1,1,0,0,0, 5'd0,0,0,0, 5'd0,0,0, 2'd0,2'd0,0,0},
    // R10 BNE unequal -> taken
    '{4'd10,5'd1, 5'd2, 1,1,1,1,1,0,0, 5'd0,0,0,0, 5'd0,0,0, 2'd0,2'd0,0,1},
    // R10 BNE equal -> not taken
    '{4'd10,5'd1, 5'd2, 1,1,1,1,1,0,1, 5'd0,0,0,0, 5'd0,0,0, 2'd0,2'd0,0,0},
    // R11 stall beats taken branch
    '{4'd11,5'd4, 5'd2, 1,1,1,1,0,0,1, 5'd4,1,1,0, 5'd0,0,0, 2'd1,2'd0,1,0},
    // R12 decode nop is quiet
    '{4'd12,5'd4, 5'd4, 1,1,0,1,0,1,1, 5'd4,1,1,0, 5'd4,1,0, 2'd0,2'd0,0,0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    rs1 = v.rs1; rs2 = v.rs2; use1 = v.u1; use2 = v.u2;
    id_valid = v.idv; is_br = v.br; br_ne = v.ne; is_jal = v.jal; op_eq = v.eq;
    ex_rd = v.exrd; ex_we = v.exwe; ex_ld = v.exld; ex_nop = v.exnop;
    mem_rd = v.memrd; mem_we = v.memwe; mem_nop = v.memnop;
  endtask

  task automatic check_vec(input vec_t v);
    string t;
    t = $sformatf("R%0d", v.req);
    chk({t, " fwd_a"}, 32'(fwd_a), 32'(v.ea));
    chk({t, " fwd_b"}, 32'(fwd_b), 32'(v.eb));
    chk({t, " stall"}, 32'(stall), 32'(v.es));
    chk({t, " bubble"}, 32'(bubble), 32'(v.es));
    chk({t, " flush"}, 32'(flush), 32'(v.ef));
    chk({t, " redirect"}, 32'(redirect), 32'(v.ef));
  endtask

  initial begin
    vec_t z;
    z = '0;
    rst_n = 1'b0;
    drive(z);
    repeat (2) @(negedge clk);
    // reset state with quiet inputs (R12)
    chk("R12 reset fwd_a", 32'(fwd_a), 0);
    chk("R12 reset stall", 32'(stall), 0);
    chk("R12 reset flush", 32'(flush), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #2;
      check_vec(TBL[i]);
    end

    // R8 sequence: stall cycle, then the load sits in memory
    @(negedge clk);
    z = '0;
    z.req = 4'd8; z.rs1 = 5'd7; z.u1 = 1; z.idv = 1;
    z.exrd = 5'd7; z.exwe = 1; z.exld = 1;
    drive(z); #2;
    chk("R8 seq stall", 32'(stall), 1);
    @(negedge clk);
    z.exrd = 5'd0; z.exwe = 0; z.exld = 0;   // bubble now in execute
    z.memrd = 5'd7; z.memwe = 1;
    drive(z); #2;
    chk("R8 seq stall released", 32'(stall), 0);
    chk("R8 seq mem forward", 32'(fwd_a), 2);

    // R7 JAL with use flags high and a matching load still no stall
    @(negedge clk);
    z = '0; z.rs1 = 5'd3; z.rs2 = 5'd3; z.u1 = 1; z.u2 = 1; z.idv = 1; z.jal = 1;
    z.exrd = 5'd3; z.exwe = 1; z.exld = 1;
    drive(z); #2;
    chk("R7 jal no stall", 32'(stall), 0);
    chk("R7 jal redirect", 32'(redirect), 1);

    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule